// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Minimum Output

This block compares two unsigned operands of a parameterised width and reports which is larger, or whether they match, on three mutually exclusive flags. It also passes the smaller operand to a separate output. The logic is purely combinational: a chain of single-bit decision cells is walked from the top bit towards bit 0. Each cell either keeps a verdict that a more significant cell already reached, or settles the verdict from its own bit pair while everything above it still matches.

Three cascade inputs feed the top of the chain. For a standalone comparison they are tied to "equal so far" (greater 0, equal 1, less 0). To build a wider comparator, several units are stacked. The three flags of the more significant unit drive the cascade inputs of the next lower unit. The flags of the lowest unit then give the verdict for the full width. The minimum output is a 2-to-1 selection driven by the "less than" flag: it presents A when that flag is 1 and B in every other case, which includes equality.

Top module: `mag_min_cmp`

## Requirements
- R1: With cascade inputs greater=0, equal=1, less=0 and unsigned A > B, the outputs are a_gt_b_o=1, a_eq_b_o=0, a_lt_b_o=0.
- R2: With the standalone cascade setting and unsigned A < B, the outputs are a_lt_b_o=1, a_gt_b_o=0, a_eq_b_o=0.
- R3: With the standalone cascade setting and A == B, the outputs are a_eq_b_o=1 with the other two flags 0, and min_o equals B.
- R4: Whenever exactly one cascade input is 1, exactly one of the three flag outputs is 1.
- R5: casc_gt_i=1 (the other cascade inputs 0) gives a_gt_b_o=1 for any A and B.
- R6: casc_lt_i=1 (the other cascade inputs 0) gives a_lt_b_o=1 and min_o=A for any A and B.
- R7: min_o equals A when a_lt_b_o is 1 and equals B otherwise, so in a standalone comparison min_o is the unsigned minimum of A and B.
- R8: Two units, where the upper unit takes the high half of each operand with the standalone setting and its three flags drive the cascade inputs of the lower unit, give flags on the lower unit that match an unsigned compare of the full concatenated operands.
- R9: The verdict is set by the most significant differing bit. For example, A=8'h0B and B=8'h09 first differ at bit 1, which gives a_gt_b_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| casc_gt_i | input | 1 | Verdict from a more significant unit: A greater |
| casc_eq_i | input | 1 | Verdict from a more significant unit: equal so far |
| casc_lt_i | input | 1 | Verdict from a more significant unit: A less |
| a_gt_b_o | output | 1 | A greater than B |
| a_eq_b_o | output | 1 | A equal to B |
| a_lt_b_o | output | 1 | A less than B |
| min_o | output | WIDTH | A when a_lt_b_o is 1, otherwise B |

## Verification
The bench builds the main instance with the default WIDTH of 8. This allows all-zero and all-one corners, single-bit differences at the top and bottom bit, and forced cascade verdicts to be applied directly. It also builds two units with WIDTH of 4 that are chained into an 8-bit comparator. This brings the hand-off of the flags between units (R8) within reach: the same operands drive both the single unit and the chained pair, so any difference between them shows up.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

    localparam verdict_t VERDICT_STANDALONE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
    import mag_cmp_pkg::*;
(
    input  logic     a_bit_i,
    input  logic     b_bit_i,
    input  verdict_t upper_i,
    output verdict_t lower_o
);

    verdict_t cell_d;

    always_comb begin
        cell_d    = '0;
        // a verdict reached above is kept; only "equal so far" is refined here
        cell_d.gt = upper_i.gt | (upper_i.eq & a_bit_i & ~b_bit_i);
        cell_d.lt = upper_i.lt | (upper_i.eq & ~a_bit_i & b_bit_i);
        cell_d.eq = upper_i.eq & ~(a_bit_i ^ b_bit_i);
    end

    assign lower_o = cell_d;

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  verdict_t         cascade_i,
    output verdict_t         result_o
);

    localparam int LINKS = WIDTH + 1;

    verdict_t link_d [LINKS];

    assign link_d[WIDTH] = cascade_i;

    for (genvar bit_g = WIDTH - 1; bit_g >= 0; bit_g--) begin : g_cell
        cmp_bit_cell cell_i (
            .a_bit_i (a_i[bit_g]),
            .b_bit_i (b_i[bit_g]),
            .upper_i (link_d[bit_g+1]),
            .lower_o (link_d[bit_g])
        );
    end

    assign result_o = link_d[0];

endmodule

// File: rtl/min_select.sv
module min_select #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             pick_a_i,
    output logic [WIDTH-1:0] min_o
);

    logic [WIDTH-1:0] min_d;

    always_comb begin
        min_d = b_i;
        if (pick_a_i) begin
            min_d = a_i;
        end
    end

    assign min_o = min_d;

endmodule

// File: rtl/mag_min_cmp.sv
module mag_min_cmp
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             casc_gt_i,
    input  logic             casc_eq_i,
    input  logic             casc_lt_i,
    output logic             a_gt_b_o,
    output logic             a_eq_b_o,
    output logic             a_lt_b_o,
    output logic [WIDTH-1:0] min_o
);

    verdict_t cascade_d;
    verdict_t verdict_d;

    always_comb begin
        cascade_d    = '0;
        cascade_d.gt = casc_gt_i;
        cascade_d.eq = casc_eq_i;
        cascade_d.lt = casc_lt_i;
    end

    cmp_ripple_chain #(.WIDTH(WIDTH)) chain_i (
        .a_i       (a_i),
        .b_i       (b_i),
        .cascade_i (cascade_d),
        .result_o  (verdict_d)
    );

    min_select #(.WIDTH(WIDTH)) pick_i (
        .a_i      (a_i),
        .b_i      (b_i),
        .pick_a_i (verdict_d.lt),
        .min_o    (min_o)
    );

    assign a_gt_b_o = verdict_d.gt;
    assign a_eq_b_o = verdict_d.eq;
    assign a_lt_b_o = verdict_d.lt;

endmodule

// File: rtl/mag_min_cmp_chk.sv
module mag_min_cmp_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             casc_gt_i,
    input logic             casc_eq_i,
    input logic             casc_lt_i,
    input logic             a_gt_b_o,
    input logic             a_eq_b_o,
    input logic             a_lt_b_o,
    input logic [WIDTH-1:0] min_o
);

    logic standalone;
    logic valid_casc;

    assign standalone = casc_eq_i & ~casc_gt_i & ~casc_lt_i;
    assign valid_casc = $onehot({casc_gt_i, casc_eq_i, casc_lt_i});

    always_comb begin
        if (standalone) begin
            AST_GT_MATCH: assert (a_gt_b_o == (a_i > b_i)); // R1
            AST_LT_MATCH: assert (a_lt_b_o == (a_i < b_i)); // R2
            AST_EQ_MATCH: assert (a_eq_b_o == (a_i == b_i)); // R3
            AST_MIN_BOUND: assert ((min_o <= a_i) && (min_o <= b_i)); // R7
        end
        if (valid_casc) begin
            AST_ONE_FLAG: assert ($countones({a_gt_b_o, a_eq_b_o, a_lt_b_o}) == 1); // R4
        end
        if (casc_gt_i && !casc_eq_i && !casc_lt_i) begin
            AST_GT_FORCED: assert (a_gt_b_o && min_o == b_i); // R5
        end
        if (casc_lt_i && !casc_eq_i && !casc_gt_i) begin
            AST_LT_FORCED: assert (a_lt_b_o && min_o == a_i); // R6
        end
    end

endmodule

bind mag_min_cmp mag_min_cmp_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i       (a_i),
    .b_i       (b_i),
    .casc_gt_i (casc_gt_i),
    .casc_eq_i (casc_eq_i),
    .casc_lt_i (casc_lt_i),
    .a_gt_b_o  (a_gt_b_o),
    .a_eq_b_o  (a_eq_b_o),
    .a_lt_b_o  (a_lt_b_o),
    .min_o     (min_o)
);

// File: tb/mag_min_cmp_tb_top.sv
module mag_min_cmp_tb_top;

    localparam int W  = 8;
    localparam int HW = W / 2;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [2:0]   casc;  // {gt, eq, lt}
        logic [2:0]   flags; // {gt, eq, lt}
        logic [W-1:0] min;
        logic         wide;  // also check the chained pair
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0] a_s = '0;
    logic [W-1:0] b_s = '0;
    logic [2:0]   casc_s = 3'b010;
    logic         gt_w, eq_w, lt_w;
    logic [W-1:0] min_w;

    mag_min_cmp #(.WIDTH(W)) dut_i (
        .a_i (a_s), .b_i (b_s),
        .casc_gt_i (casc_s[2]), .casc_eq_i (casc_s[1]), .casc_lt_i (casc_s[0]),
        .a_gt_b_o (gt_w), .a_eq_b_o (eq_w), .a_lt_b_o (lt_w), .min_o (min_w)
    );

    // chained pair: upper unit on high nibbles, lower unit on low nibbles
    logic          hgt, heq, hlt, lgt, leq, llt;
    logic [HW-1:0] hmin, lmin;

    mag_min_cmp #(.WIDTH(HW)) hi_i (
        .a_i (a_s[W-1:HW]), .b_i (b_s[W-1:HW]),
        .casc_gt_i (1'b0), .casc_eq_i (1'b1), .casc_lt_i (1'b0),
        .a_gt_b_o (hgt), .a_eq_b_o (heq), .a_lt_b_o (hlt), .min_o (hmin)
    );

    mag_min_cmp #(.WIDTH(HW)) lo_i (
        .a_i (a_s[HW-1:0]), .b_i (b_s[HW-1:0]),
        .casc_gt_i (hgt), .casc_eq_i (heq), .casc_lt_i (hlt),
        .a_gt_b_o (lgt), .a_eq_b_o (leq), .a_lt_b_o (llt), .min_o (lmin)
    );

    item_t expq[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    logic  done     = 1'b0;

    function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b,
                                    logic [2:0] casc, string tag);
        item_t it;
        it.a = a; it.b = b; it.casc = casc; it.tag = tag;
        if (casc[2])      it.flags = 3'b100;
        else if (casc[0]) it.flags = 3'b001;
        else if (casc[1]) it.flags = {a > b, a == b, a < b};
        else              it.flags = 3'b000;
        it.min  = it.flags[0] ? a : b;
        it.wide = (casc == 3'b010);
        return it;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] casc, string tag);
        @(negedge clk);
        a_s = a; b_s = b; casc_s = casc;
        expq.push_back(model(a, b, casc, tag));
    endtask

    // monitor: compares each pushed item at the following rising edge
    always @(posedge clk) begin
        if (!rst && expq.size() > 0) begin
            item_t it;
            it = expq.pop_front();
            n_checks++;
            if ({gt_w, eq_w, lt_w} !== it.flags) begin
                n_fails++;
                $display("FAIL %s flags a=%h b=%h casc=%b actual=%b expected=%b",
                         it.tag, it.a, it.b, it.casc, {gt_w, eq_w, lt_w}, it.flags);
            end
            n_checks++;
            if (min_w !== it.min) begin
                n_fails++;
                $display("FAIL %s min a=%h b=%h actual=%h expected=%h",
                         it.tag, it.a, it.b, min_w, it.min);
            end
            if (it.wide) begin
                n_checks++;
                if ({lgt, leq, llt} !== it.flags) begin
                    n_fails++;
                    $display("FAIL R8 chained a=%h b=%h actual=%b expected=%b",
                             it.a, it.b, {lgt, leq, llt}, it.flags);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // initial state: zero operands, standalone -> equal, min 0 (R3)
        drive(8'h00, 8'h00, 3'b010, "R3 initial");
        drive(8'hFF, 8'hFF, 3'b010, "R3 all-ones");
        drive(8'h5A, 8'h5A, 3'b010, "R3 equal");
        drive(8'hFF, 8'h00, 3'b010, "R1 max>min");
        drive(8'h80, 8'h7F, 3'b010, "R1 top bit");
        drive(8'h01, 8'h00, 3'b010, "R1 bottom bit");
        drive(8'h00, 8'hFF, 3'b010, "R2 min<max");
        drive(8'h7F, 8'h80, 3'b010, "R2 top bit");
        drive(8'h10, 8'h11, 3'b010, "R2 bottom bit");
        drive(8'h0B, 8'h09, 3'b010, "R9 first diff bit1");
        drive(8'h09, 8'h0B, 3'b010, "R9 reversed");
        drive(8'h00, 8'hFF, 3'b100, "R5 forced gt");
        drive(8'h33, 8'h33, 3'b100, "R5 forced gt equal ops");
        drive(8'hFF, 8'h00, 3'b001, "R6 forced lt");
        drive(8'h44, 8'h44, 3'b001, "R6 forced lt equal ops");
        drive(8'hC3, 8'h3C, 3'b001, "R4 one flag lt");
        drive(8'h0F, 8'hF0, 3'b010, "R8 nibble split");
        drive(8'hF0, 8'hF1, 3'b010, "R8 high nibbles equal");
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 5 == 0) ? ra ^ W'(1 << (i % W)) : W'($urandom);
            drive(ra, rb, 3'b010, "R7 random");
        end
        for (int i = 0; i < 40; i++) begin
            logic [2:0] c;
            c = (i % 3 == 0) ? 3'b100 : ((i % 3 == 1) ? 3'b001 : 3'b010);
            drive(W'($urandom), W'($urandom), c, "R4 random cascade");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule